// File: doc/BRIEF.md
# Vector Clock Causality Tracker

This block keeps the logical time of one processor in a small shared-memory multiprocessor model. It holds one saturating counter per processor in the system, and the processor it belongs to is fixed by a static index parameter. A memory barrier executed by that processor steps its own counter. Each load or store to a shared cache block combines the processor clock with the clock carried by that block, entry by entry. The block's updated clock goes back out, and the processor keeps the same entry-wise maximum. This way causal history moves in both directions through shared data.

The unit also drives the two stamps used by the coherence messages. The full current vector goes on outgoing invalidate requests when a store misses. An expiration stamp, equal to the own counter plus a fixed lease, goes into an invalidate acknowledgement when the processor wants to keep reading a stale copy. When this processor is the writer and receives such an acknowledgement, the stamp is merged into the entry of the processor that sent it. After that, the writer is ordered after the stale-data user.

Top module: `vclock_tracker`

## Requirements
- R1: After reset every counter is zero, so `inv_ts_o` reads all zeros and `exp_ts_o` reads the lease value.
- R2: A cycle with only `barrier_i` high raises the own entry (entry SELF_ID, bits [SELF_ID*CNT_W +: CNT_W]) by one on the next clock and leaves every other entry unchanged.
- R3: Counters saturate at the all-ones value and never wrap; no entry ever decreases.
- R4: While `access_i` is high, `blk_clk_o` shows without delay the entry-wise maximum of the current clock and `blk_clk_i`. Entry i sits at bits [i*CNT_W +: CNT_W] in every vector port.
- R5: An access updates every entry of the processor clock to the maximum of itself and the block entry on the next clock. A block entry smaller than the processor entry has no effect.
- R6: When a barrier and an access fall in the same cycle, the merge is applied first and the own entry is then incremented by one.
- R7: `inv_ts_o` always shows the processor's present vector.
- R8: `exp_ts_o` equals the own entry plus LEASE (default 4), saturating at all ones.
- R9: With `ack_valid_i` high, entry `ack_src_i` becomes the maximum of itself and `ack_exp_i` on the next clock. All other entries are untouched.
- R10: In a cycle with no barrier, access or acknowledgement, the clock keeps its value.
- R11: An acknowledgement and an access in the same cycle both take effect in that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| barrier_i | input | 1 | The processor executes a memory barrier this cycle |
| access_i | input | 1 | Load or store to a shared block this cycle |
| blk_clk_i | input | N_PROC*CNT_W | Clock carried by the accessed block |
| blk_clk_o | output | N_PROC*CNT_W | Updated clock to write back to the block |
| ack_valid_i | input | 1 | An invalidate acknowledgement with an expiration stamp arrives |
| ack_src_i | input | SRC_W | Processor index that sent the acknowledgement |
| ack_exp_i | input | CNT_W | Expiration stamp carried by the acknowledgement |
| inv_ts_o | output | N_PROC*CNT_W | Current vector, attached to outgoing invalidate requests |
| exp_ts_o | output | CNT_W | Own entry plus lease, for invalidate acknowledgements |

## Verification
The bench targets the ordering of a barrier that lands on the same cycle as a merge. If the design increments before merging, it loses the step whenever the block entry is larger. It also targets saturation near the top of the counter range. Wrap-around there would send the own entry back to zero and make the expiration stamp look older than the present. Acknowledgements carrying a smaller stamp must not lower an entry, and block entries below the processor's must not pull it down. An acknowledgement that also arrives with an access must not be dropped. A design that applied the stamp to the wrong index, or let one source override the other, would leave a wrong entry in the vector.

// File: rtl/vclock_pkg.sv
// Package: shared types for the vector clock tracker.
// Assumes: nothing beyond SystemVerilog 2017.
package vclock_pkg;

    // Which merge inputs apply to one counter in a given cycle.
    typedef enum logic [1:0] {
        MRG_NONE  = 2'b00,
        MRG_BLOCK = 2'b01,
        MRG_ACK   = 2'b10,
        MRG_BOTH  = 2'b11
    } merge_src_e;

endpackage

// File: rtl/vclock_max2.sv
// Module: unsigned maximum of two counters.
// Assumes: both operands are unsigned and W bits wide.
module vclock_max2 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    // Select the larger operand.
    always_comb begin
        y_o = (a_i > b_i) ? a_i : b_i;
    end

endmodule

// File: rtl/vclock_sat_add.sv
// Module: adds a constant to a counter and clamps at all ones.
// Assumes: INC is non-negative and fits in W bits.
module vclock_sat_add #(
    parameter int W   = 8,
    parameter int INC = 1
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);

    localparam logic [W:0] INC_X = (W+1)'(INC);

    logic [W:0] sum;

    // Widen by one bit and clamp on carry out.
    always_comb begin
        sum = {1'b0, a_i} + INC_X;
        y_o = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

endmodule

// File: rtl/vclock_entry.sv
// Module: one counter of the vector clock. Merge sources are applied first,
//         then the optional saturating step.
// Assumes: bump_i is only ever driven high for the processor's own entry.
module vclock_entry
    import vclock_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blk_en_i,
    input  logic [W-1:0] blk_val_i,
    input  logic         ack_en_i,
    input  logic [W-1:0] ack_val_i,
    input  logic         bump_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] max_blk;
    logic [W-1:0] max_ack;
    logic [W-1:0] max_both;
    logic [W-1:0] merged;
    logic [W-1:0] stepped;
    logic [W-1:0] cnt_d;
    merge_src_e   src;

    vclock_max2 #(.W(W)) u_max_blk  (.a_i(cnt_q),   .b_i(blk_val_i), .y_o(max_blk));
    vclock_max2 #(.W(W)) u_max_ack  (.a_i(cnt_q),   .b_i(ack_val_i), .y_o(max_ack));
    vclock_max2 #(.W(W)) u_max_both (.a_i(max_blk), .b_i(ack_val_i), .y_o(max_both));
    vclock_sat_add #(.W(W), .INC(1)) u_step (.a_i(merged), .y_o(stepped));

    // Pick the merged value from the active sources.
    always_comb begin
        src = merge_src_e'({ack_en_i, blk_en_i});
        case (src)
            MRG_BLOCK: merged = max_blk;
            MRG_ACK:   merged = max_ack;
            MRG_BOTH:  merged = max_both;
            default:   merged = cnt_q;
        endcase
        cnt_d = bump_i ? stepped : merged;
    end

    // Hold the counter; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/vclock_tracker.sv
// Module: per-processor vector clock. Keeps N_PROC saturating counters and
//         steps entry SELF_ID on a barrier. Merges two ways with block clocks
//         on shared accesses, merges acknowledgement stamps, and drives the
//         invalidate and expiration stamps.
// Assumes: ack_src_i < N_PROC; entry i of every vector is bits [i*CNT_W +: CNT_W].
module vclock_tracker #(
    parameter int N_PROC  = 4,
    parameter int CNT_W   = 8,
    parameter int SELF_ID = 0,
    parameter int LEASE   = 4,
    parameter int SRC_W   = (N_PROC > 1) ? $clog2(N_PROC) : 1,
    parameter int VEC_W   = N_PROC * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             barrier_i,
    input  logic             access_i,
    input  logic [VEC_W-1:0] blk_clk_i,
    output logic [VEC_W-1:0] blk_clk_o,
    input  logic             ack_valid_i,
    input  logic [SRC_W-1:0] ack_src_i,
    input  logic [CNT_W-1:0] ack_exp_i,
    output logic [VEC_W-1:0] inv_ts_o,
    output logic [CNT_W-1:0] exp_ts_o
);

    logic [CNT_W-1:0] cnt [N_PROC];

    for (genvar i = 0; i < N_PROC; i++) begin : g_ent
        logic ack_hit;

        // The acknowledgement only touches the sender's entry.
        always_comb begin
            ack_hit = ack_valid_i && (ack_src_i == SRC_W'(i));
        end

        vclock_entry #(.W(CNT_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .blk_en_i  (access_i),
            .blk_val_i (blk_clk_i[i*CNT_W +: CNT_W]),
            .ack_en_i  (ack_hit),
            .ack_val_i (ack_exp_i),
            .bump_i    (barrier_i && (i == SELF_ID)),
            .cnt_o     (cnt[i])
        );

        vclock_max2 #(.W(CNT_W)) u_blk_out (
            .a_i (cnt[i]),
            .b_i (blk_clk_i[i*CNT_W +: CNT_W]),
            .y_o (blk_clk_o[i*CNT_W +: CNT_W])
        );

        assign inv_ts_o[i*CNT_W +: CNT_W] = cnt[i];
    end

    vclock_sat_add #(.W(CNT_W), .INC(LEASE)) u_lease (
        .a_i (cnt[SELF_ID]),
        .y_o (exp_ts_o)
    );

endmodule

// File: rtl/vclock_tracker_chk.sv
// Module: property checker for vclock_tracker, attached by bind.
// Assumes: the same parameters as the tracker it watches.
module vclock_tracker_chk #(
    parameter int N_PROC  = 4,
    parameter int CNT_W   = 8,
    parameter int SELF_ID = 0,
    parameter int SRC_W   = 2,
    parameter int VEC_W   = N_PROC * CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             barrier_i,
    input logic             access_i,
    input logic [VEC_W-1:0] blk_clk_i,
    input logic [VEC_W-1:0] blk_clk_o,
    input logic             ack_valid_i,
    input logic [SRC_W-1:0] ack_src_i,
    input logic [CNT_W-1:0] ack_exp_i,
    input logic [VEC_W-1:0] inv_ts_o,
    input logic [CNT_W-1:0] exp_ts_o
);

    logic [CNT_W-1:0] own;
    assign own = inv_ts_o[SELF_ID*CNT_W +: CNT_W];

    // R2: a lone barrier below the ceiling steps the own entry by one.
    a_r2_barrier_step: assert property (@(posedge clk) disable iff (!rst_n)
        (barrier_i && !access_i && !ack_valid_i && (own != {CNT_W{1'b1}}))
        |=> (own == $past(own) + CNT_W'(1)));

    // R10: no event, no change.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!barrier_i && !access_i && !ack_valid_i) |=> $stable(inv_ts_o));

    // R8: the expiration stamp never trails the own entry.
    a_r8_lease_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        exp_ts_o >= own);

    for (genvar i = 0; i < N_PROC; i++) begin : g_prop
        // R3: entries never move backward (no wrap).
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (inv_ts_o[i*CNT_W +: CNT_W] >= $past(inv_ts_o[i*CNT_W +: CNT_W])));

        // R4: the returned block clock dominates both inputs.
        a_r4_block_dominates: assert property (@(posedge clk) disable iff (!rst_n)
            access_i |-> ((blk_clk_o[i*CNT_W +: CNT_W] >= blk_clk_i[i*CNT_W +: CNT_W]) &&
                          (blk_clk_o[i*CNT_W +: CNT_W] >= inv_ts_o[i*CNT_W +: CNT_W])));

        // R9: a lone acknowledgement leaves every other entry alone.
        a_r9_ack_local: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid_i && !access_i && !barrier_i && (ack_src_i != SRC_W'(i)))
            |=> $stable(inv_ts_o[i*CNT_W +: CNT_W]));
    end

endmodule

bind vclock_tracker vclock_tracker_chk #(
    .N_PROC  (N_PROC),
    .CNT_W   (CNT_W),
    .SELF_ID (SELF_ID),
    .SRC_W   (SRC_W),
    .VEC_W   (VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .barrier_i   (barrier_i),
    .access_i    (access_i),
    .blk_clk_i   (blk_clk_i),
    .blk_clk_o   (blk_clk_o),
    .ack_valid_i (ack_valid_i),
    .ack_src_i   (ack_src_i),
    .ack_exp_i   (ack_exp_i),
    .inv_ts_o    (inv_ts_o),
    .exp_ts_o    (exp_ts_o)
);

// File: tb/vclock_tracker_test.sv
// Bench: scoreboard for vclock_tracker. The driver keeps a reference model
//        and queues expected post-edge state; the monitor compares it.
module vclock_tracker_test;

    localparam int N     = 4;
    localparam int W     = 8;
    localparam int SELF  = 2;
    localparam int LEASE = 4;
    localparam int SW    = 2;
    localparam int VW    = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          barrier_i = 1'b0;
    logic          access_i = 1'b0;
    logic [VW-1:0] blk_clk_i = '0;
    logic [VW-1:0] blk_clk_o;
    logic          ack_valid_i = 1'b0;
    logic [SW-1:0] ack_src_i = '0;
    logic [W-1:0]  ack_exp_i = '0;
    logic [VW-1:0] inv_ts_o;
    logic [W-1:0]  exp_ts_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0]  model [N];
    logic [VW-1:0] q_vec [$];
    logic [W-1:0]  q_exp [$];
    string         q_tag [$];
    bit            done = 1'b0;

    vclock_tracker #(.N_PROC(N), .CNT_W(W), .SELF_ID(SELF), .LEASE(LEASE)) uut (
        .clk(clk), .rst_n(rst_n), .barrier_i(barrier_i), .access_i(access_i),
        .blk_clk_i(blk_clk_i), .blk_clk_o(blk_clk_o), .ack_valid_i(ack_valid_i),
        .ack_src_i(ack_src_i), .ack_exp_i(ack_exp_i), .inv_ts_o(inv_ts_o),
        .exp_ts_o(exp_ts_o)
    );

    always #5 clk = ~clk;

    function automatic logic [VW-1:0] mk(input int e0, input int e1, input int e2, input int e3);
        return {W'(e3), W'(e2), W'(e1), W'(e0)};
    endfunction

    function automatic logic [W-1:0] sat(input int v);
        return (v > 255) ? 8'hFF : W'(v);
    endfunction

    function automatic logic [VW-1:0] model_vec();
        logic [VW-1:0] v;
        for (int j = 0; j < N; j++) v[j*W +: W] = model[j];
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic do_op(input bit bar, input bit acc, input logic [VW-1:0] blk,
                         input bit ackv, input int src, input int expv, input string tag);
        logic [VW-1:0] want_blk;
        @(negedge clk);
        barrier_i = bar; access_i = acc; blk_clk_i = blk;
        ack_valid_i = ackv; ack_src_i = SW'(src); ack_exp_i = W'(expv);
        #1;
        if (acc) begin
            for (int j = 0; j < N; j++)
                want_blk[j*W +: W] = (model[j] > blk[j*W +: W]) ? model[j] : blk[j*W +: W];
            check(blk_clk_o == want_blk, {tag, " R4 block out"}, blk_clk_o, want_blk);
        end
        for (int j = 0; j < N; j++) begin
            if (acc && blk[j*W +: W] > model[j]) model[j] = blk[j*W +: W];
            if (ackv && j == src && W'(expv) > model[j]) model[j] = W'(expv);
        end
        if (bar) model[SELF] = sat(int'(model[SELF]) + 1);
        q_vec.push_back(model_vec());
        q_exp.push_back(sat(int'(model[SELF]) + LEASE));
        q_tag.push_back(tag);
    endtask

    // Monitor: after each rising edge, compare the registered outputs.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_vec.size() > 0) begin
                logic [VW-1:0] ev;
                logic [W-1:0]  ee;
                string         t;
                ev = q_vec.pop_front();
                ee = q_exp.pop_front();
                t  = q_tag.pop_front();
                check(inv_ts_o == ev, {t, " R7 vector"}, inv_ts_o, ev);
                check(exp_ts_o == ee, {t, " R8 expiration"}, VW'(exp_ts_o), VW'(ee));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < N; j++) model[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: cleared vector, stamp equals the lease.
        check(inv_ts_o == '0, "R1 reset vector", inv_ts_o, '0);
        check(exp_ts_o == W'(LEASE), "R1 reset stamp", VW'(exp_ts_o), VW'(LEASE));

        do_op(0, 0, '0, 0, 0, 0, "R10 idle after reset");
        do_op(1, 0, '0, 0, 0, 0, "R2 barrier 1");
        do_op(1, 0, '0, 0, 0, 0, "R2 barrier 2");
        do_op(1, 0, '0, 0, 0, 0, "R2 barrier 3");
        do_op(0, 1, mk(5, 0, 1, 9), 0, 0, 0, "R5 access merge");
        do_op(0, 1, mk(1, 1, 1, 1), 0, 0, 0, "R5 smaller block no effect");
        do_op(1, 1, mk(0, 0, 7, 0), 0, 0, 0, "R6 merge then step");
        do_op(0, 0, '0, 1, 1, 12, "R9 ack raises sender");
        do_op(0, 0, '0, 1, 3, 2, "R9 ack smaller stamp");
        do_op(0, 1, mk(10, 0, 0, 40), 1, 0, 30, "R11 ack with access");
        do_op(0, 0, mk(200, 200, 200, 200), 0, 0, 0, "R10 idle ignores block");
        do_op(0, 1, mk(0, 0, 254, 0), 0, 0, 0, "R8 stamp saturates");
        do_op(1, 0, '0, 0, 0, 0, "R3 step to ceiling");
        do_op(1, 0, '0, 0, 0, 0, "R3 hold at ceiling");
        do_op(1, 1, mk(255, 0, 255, 0), 0, 0, 0, "R3 R6 merge and step at ceiling");
        do_op(0, 0, '0, 0, 0, 0, "R10 final idle");

        while (q_vec.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule